// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is a small bus-master DMA engine with two channels. The outbound channel takes 32-bit words from an outbound FIFO and writes them to memory. The inbound channel reads words from memory and places them in an inbound FIFO. Software programs each channel through a register port: a word-aligned start address, a length in bytes, a shared run-control register that holds both channel enables, and an event register that holds the completion flags, the conflict flags and the interrupt enables.

Memory traffic uses a request/acknowledge port that carries one word at a time. A length that is not a multiple of four ends with a partial word whose byte enables cover only the remaining low-order bytes. Each FIFO is also reachable directly through a data window in the register map. The host fills the outbound FIFO by writing the window and empties the inbound FIFO by reading it. While the channel of the same direction is enabled, such an access is refused and a conflict flag records it.

Register map (word index on `regAddr`): 0 outbound address, 1 outbound byte count, 2 inbound address, 3 inbound byte count, 4 run control, 5 event register, 6 FIFO data window.

Top module: `dma_bm_top`

## Requirements
- R1: The two low bits of each address register (indices 0 and 2) always read 0, whatever value was written, and every memory request carries a word-aligned address.
- R2: A byte count of 0 is legal. Enabling a channel whose count is 0 sets its completion flag within two cycles and issues no memory request.
- R3: Writing 1 to bit 10 (outbound) or bit 14 (inbound) of the run-control register (index 4) starts that channel. A channel issues requests only after its enable bit was 1.
- R4: A write to the run-control register stops any channel whose enable bit is 0 in the written data, even when the write was meant for the other channel. The stopped channel issues no further request and sets no completion flag.
- R5: Each acknowledged word advances the channel address by 4 and lowers its byte count by 4, or by the remaining count when that is below 4. Both registers read back the current values.
- R6: Byte enables are 4'b1111 for full words. The final word of a count that is not a multiple of four uses 4'b0001, 4'b0011 or 4'b0111 for 1, 2 or 3 remaining bytes. On inbound transfers the disabled bytes are stored as zero.
- R7: When a channel finishes, it sets its completion flag in the event register (index 5): bit 18 for outbound, bit 19 for inbound. In the same cycle it clears its own enable bit.
- R8: Writing 1 to a completion or conflict flag clears it. Writing 0 leaves it unchanged.
- R9: With interrupt enables at bit 0 (outbound) and bit 1 (inbound) of the event register, `irq` is high while any completion flag is set together with its enable. With the enable at 0, `irq` stays low and the flag can still be polled.
- R10: Writing the FIFO window (index 6) pushes the outbound FIFO, and reading it pops the inbound FIFO. While the channel of the same direction is enabled, the access is refused: the data is dropped, or the read returns 0. Refusal sets bit 20 (outbound) or bit 21 (inbound) of the event register.
- R11: Once raised, `memReq` together with its address, direction and byte enables holds steady until `memAck`.
- R12: When both channels are ready, the memory port alternates words between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the FIFO window) |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory word request |
| memWrite | output | 1 | 1 = write to memory, 0 = read |
| memAddr | output | 32 | Word-aligned memory address |
| memBe | output | 4 | Byte enables |
| memWData | output | 32 | Write data |
| memRData | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Acknowledges the current request |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume a memory side that keeps `memAck` low unless `memReq` is high, and that acknowledges each request exactly once. The bench's responder raises `memAck` only against a request it has watched for two cycles, then drops it. The assertions also assume that the host never writes and reads in the same cycle. The bench drives exactly one register strobe per access and deasserts it on the next falling edge. Transfers are sized so that the inbound FIFO either drains before its channel is stopped or is emptied by the host afterwards.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_WADDR  = 3'd0;
  localparam logic [REG_AW-1:0] REG_WCNT   = 3'd1;
  localparam logic [REG_AW-1:0] REG_RADDR  = 3'd2;
  localparam logic [REG_AW-1:0] REG_RCNT   = 3'd3;
  localparam logic [REG_AW-1:0] REG_RUN    = 3'd4;
  localparam logic [REG_AW-1:0] REG_EVENT  = 3'd5;
  localparam logic [REG_AW-1:0] REG_WINDOW = 3'd6;

  localparam int RUN_WR_EN   = 10;
  localparam int RUN_RD_EN   = 14;
  localparam int EV_WR_IE    = 0;
  localparam int EV_RD_IE    = 1;
  localparam int EV_WR_DONE  = 18;
  localparam int EV_RD_DONE  = 19;
  localparam int EV_WR_CONF  = 20;
  localparam int EV_RD_CONF  = 21;

  // control -> datapath strobes; channel index 0 = outbound, 1 = inbound
  typedef struct packed {
    logic [1:0] addrLoad;
    logic [1:0] cntLoad;
    logic [1:0] beat;
    logic       outPush;
    logic       inPop;
    logic       selRd;
  } dmaStrobe_t;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW:0]      wPtr, rPtr;

  always_ff @(posedge clk) begin
    if (push && !full) store[wPtr[PW-1:0]] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPtr <= '0;
      rPtr <= '0;
    end else begin
      if (push && !full) wPtr <= wPtr + 1'b1;
      if (pop && !empty) rPtr <= rPtr + 1'b1;
    end
  end

  assign headData = store[rPtr[PW-1:0]];
  assign empty    = (wPtr == rPtr);
  assign full     = (wPtr[PW] != rPtr[PW]) && (wPtr[PW-1:0] == rPtr[PW-1:0]);
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [31:0]       runWord,
  input  logic [31:0]       eventWord,
  input  logic [31:0]       memRData,
  output logic [31:0]       regRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWData,
  output logic [1:0]        cntZero,
  output logic [1:0]        lastWord,
  output logic              outEmpty,
  output logic              outFull,
  output logic              inEmpty,
  output logic              inFull
);
  localparam logic [CNT_W-1:0]  WORD_BYTES = CNT_W'(4);
  localparam logic [ADDR_W-1:0] ADDR_STEP  = ADDR_W'(4);

  logic [ADDR_W-1:0] chAddr [2];
  logic [CNT_W-1:0]  chCnt  [2];
  logic [31:0]       inHead, byteMask;

  function automatic logic [CNT_W-1:0] stepOf(input logic [CNT_W-1:0] c);
    return (c >= WORD_BYTES) ? WORD_BYTES : c;
  endfunction

  function automatic logic [3:0] enablesOf(input logic [CNT_W-1:0] c);
    if (c >= WORD_BYTES) return 4'hF;
    case (c[1:0])
      2'd1:    return 4'h1;
      2'd2:    return 4'h3;
      2'd3:    return 4'h7;
      default: return 4'h0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < 2; ch++) begin
        chAddr[ch] <= '0;
        chCnt[ch]  <= '0;
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        if (strobe.addrLoad[ch])  chAddr[ch] <= {regWrData[ADDR_W-1:2], 2'b00};
        else if (strobe.beat[ch]) chAddr[ch] <= chAddr[ch] + ADDR_STEP;
        if (strobe.cntLoad[ch])   chCnt[ch]  <= regWrData[CNT_W-1:0];
        else if (strobe.beat[ch]) chCnt[ch]  <= chCnt[ch] - stepOf(chCnt[ch]);
      end
    end
  end

  always_comb begin
    for (int ch = 0; ch < 2; ch++) begin
      cntZero[ch]  = (chCnt[ch] == '0);
      lastWord[ch] = (chCnt[ch] <= WORD_BYTES);
    end
  end

  assign memAddr = strobe.selRd ? chAddr[1] : chAddr[0];
  assign memBe   = enablesOf(strobe.selRd ? chCnt[1] : chCnt[0]);

  always_comb begin
    for (int b = 0; b < 4; b++) byteMask[8*b +: 8] = {8{memBe[b]}};
  end

  dma_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) outFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.outPush), .pushData(regWrData),
    .pop(strobe.beat[0]), .headData(memWData),
    .empty(outEmpty), .full(outFull)
  );

  dma_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) inFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.beat[1]), .pushData(memRData & byteMask),
    .pop(strobe.inPop), .headData(inHead),
    .empty(inEmpty), .full(inFull)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_WADDR:  regRdData[ADDR_W-1:0] = chAddr[0];
      REG_WCNT:   regRdData[CNT_W-1:0]  = chCnt[0];
      REG_RADDR:  regRdData[ADDR_W-1:0] = chAddr[1];
      REG_RCNT:   regRdData[CNT_W-1:0]  = chCnt[1];
      REG_RUN:    regRdData = runWord;
      REG_EVENT:  regRdData = eventWord;
      REG_WINDOW: regRdData = strobe.inPop ? inHead : '0;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              memAck,
  input  logic [1:0]        cntZero,
  input  logic [1:0]        lastWord,
  input  logic              outEmpty,
  input  logic              outFull,
  input  logic              inEmpty,
  input  logic              inFull,
  output dmaStrobe_t        strobe,
  output logic              memReq,
  output logic              memWrite,
  output logic [31:0]       runWord,
  output logic [31:0]       eventWord,
  output logic              irq
);
  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD} dmaState_t;

  dmaState_t state, stateNext;
  logic wrEn, rdEn, wrIe, rdIe, wrDone, rdDone, wrConf, rdConf, lastWasWr;
  logic runWrite, eventWrite, winWrite, winRead;
  logic wrReady, rdReady, wrDoneSet, rdDoneSet, wrConfSet, rdConfSet;

  assign runWrite   = regWrEn && (regAddr == REG_RUN);
  assign eventWrite = regWrEn && (regAddr == REG_EVENT);
  assign winWrite   = regWrEn && (regAddr == REG_WINDOW);
  assign winRead    = regRdEn && (regAddr == REG_WINDOW);

  assign wrConfSet = winWrite && wrEn;
  assign rdConfSet = winRead && rdEn;

  always_comb begin
    strobe             = '0;
    strobe.addrLoad[0] = regWrEn && (regAddr == REG_WADDR);
    strobe.cntLoad[0]  = regWrEn && (regAddr == REG_WCNT);
    strobe.addrLoad[1] = regWrEn && (regAddr == REG_RADDR);
    strobe.cntLoad[1]  = regWrEn && (regAddr == REG_RCNT);
    strobe.beat[0]     = (state == ST_WR) && memAck;
    strobe.beat[1]     = (state == ST_RD) && memAck;
    strobe.outPush     = winWrite && !wrEn && !outFull;
    strobe.inPop       = winRead && !rdEn && !inEmpty;
    strobe.selRd       = (state == ST_RD);
  end

  assign wrReady = wrEn && !cntZero[0] && !outEmpty;
  assign rdReady = rdEn && !cntZero[1] && !inFull;

  assign wrDoneSet = (strobe.beat[0] && lastWord[0]) || (wrEn && cntZero[0] && state != ST_WR);
  assign rdDoneSet = (strobe.beat[1] && lastWord[1]) || (rdEn && cntZero[1] && state != ST_RD);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (wrReady && (!rdReady || !lastWasWr)) stateNext = ST_WR;
        else if (rdReady)                        stateNext = ST_RD;
      end
      ST_WR, ST_RD: if (memAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      lastWasWr <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && stateNext == ST_WR) lastWasWr <= 1'b1;
      if (state == ST_IDLE && stateNext == ST_RD) lastWasWr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn <= 1'b0; rdEn <= 1'b0;
      wrIe <= 1'b0; rdIe <= 1'b0;
      wrDone <= 1'b0; rdDone <= 1'b0;
      wrConf <= 1'b0; rdConf <= 1'b0;
    end else begin
      if (runWrite) begin
        wrEn <= regWrData[RUN_WR_EN];
        rdEn <= regWrData[RUN_RD_EN];
      end
      if (wrDoneSet) wrEn <= 1'b0;
      if (rdDoneSet) rdEn <= 1'b0;
      if (eventWrite) begin
        wrIe <= regWrData[EV_WR_IE];
        rdIe <= regWrData[EV_RD_IE];
      end
      wrDone <= wrDoneSet | (wrDone & ~(eventWrite & regWrData[EV_WR_DONE]));
      rdDone <= rdDoneSet | (rdDone & ~(eventWrite & regWrData[EV_RD_DONE]));
      wrConf <= wrConfSet | (wrConf & ~(eventWrite & regWrData[EV_WR_CONF]));
      rdConf <= rdConfSet | (rdConf & ~(eventWrite & regWrData[EV_RD_CONF]));
    end
  end

  always_comb begin
    runWord                = '0;
    runWord[RUN_WR_EN]     = wrEn;
    runWord[RUN_RD_EN]     = rdEn;
    eventWord              = '0;
    eventWord[EV_WR_IE]    = wrIe;
    eventWord[EV_RD_IE]    = rdIe;
    eventWord[EV_WR_DONE]  = wrDone;
    eventWord[EV_RD_DONE]  = rdDone;
    eventWord[EV_WR_CONF]  = wrConf;
    eventWord[EV_RD_CONF]  = rdConf;
  end

  assign memReq   = (state != ST_IDLE);
  assign memWrite = (state == ST_WR);
  assign irq      = (wrDone & wrIe) | (rdDone & rdIe);
endmodule

// File: rtl/dma_bm_top.sv
module dma_bm_top
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWData,
  input  logic [31:0]       memRData,
  input  logic              memAck,
  output logic              irq
);
  dmaStrobe_t  strobe;
  logic [31:0] runWord, eventWord;
  logic [1:0]  cntZero, lastWord;
  logic        outEmpty, outFull, inEmpty, inFull;

  dma_control ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .memAck(memAck), .cntZero(cntZero), .lastWord(lastWord),
    .outEmpty(outEmpty), .outFull(outFull), .inEmpty(inEmpty), .inFull(inFull),
    .strobe(strobe), .memReq(memReq), .memWrite(memWrite),
    .runWord(runWord), .eventWord(eventWord), .irq(irq)
  );

  dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regAddr(regAddr), .regWrData(regWrData),
    .runWord(runWord), .eventWord(eventWord), .memRData(memRData),
    .regRdData(regRdData), .memAddr(memAddr), .memBe(memBe), .memWData(memWData),
    .cntZero(cntZero), .lastWord(lastWord),
    .outEmpty(outEmpty), .outFull(outFull), .inEmpty(inEmpty), .inFull(inFull)
  );
endmodule

// File: rtl/dma_bm_checker.sv
module dma_bm_checker
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic              memReq,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memBe,
  input logic              memAck,
  input logic              irq,
  input logic [31:0]       runWord,
  input logic [31:0]       eventWord
);
  logic eventWr;
  assign eventWr = regWrEn && (regAddr == REG_EVENT);

  p_aligned_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  p_start_needs_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReq) && memWrite) |-> $past(runWord[RUN_WR_EN]));

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBe == 4'h1 || memBe == 4'h3 || memBe == 4'h7 || memBe == 4'hF));

  p_done_drops_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eventWord[EV_WR_DONE]) |-> !runWord[RUN_WR_EN]);

  p_flag_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eventWord[EV_WR_DONE] && !(eventWr && regWrData[EV_WR_DONE])) |=> eventWord[EV_WR_DONE]);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !eventWr) |=> irq);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memBe)));
endmodule

bind dma_bm_top dma_bm_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memBe(memBe),
  .memAck(memAck), .irq(irq), .runWord(runWord), .eventWord(eventWord)
);

// File: tb/dma_bm_tb.sv
module dma_bm_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWrite, irq;
  logic [31:0] memAddr, memWData;
  logic [3:0]  memBe;
  logic [31:0] memRData = '0;
  logic        memAck = 1'b0;

  int checks = 0, failures = 0;
  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  logic [3:0]  logBe   [64];
  logic        logWr   [64];
  int logCount = 0;

  always #10 clk = ~clk;

  dma_bm_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memBe(memBe), .memWData(memWData), .memRData(memRData),
    .memAck(memAck), .irq(irq)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {~a[7:0], a[7:0], 8'h5A, a[15:8]};
  endfunction

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // memory responder: acknowledges two cycles after first sighting
  initial begin
    logic        pending = 1'b0;
    logic [31:0] firstAddr = '0;
    logic        firstWr = 1'b0;
    int          holdCnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (!pending) begin
          pending = 1'b1; firstAddr = memAddr; firstWr = memWrite; holdCnt = 1;
        end else begin
          checkEq("R11 request held", {memAddr[31:1], memWrite}, {firstAddr[31:1], firstWr});
          if (holdCnt > 0) holdCnt--;
          else begin
            memAck = 1'b1;
            memRData = memWord(memAddr);
            if (logCount < 64) begin
              logAddr[logCount] = memAddr; logData[logCount] = memWData;
              logBe[logCount] = memBe; logWr[logCount] = memWrite;
              logCount++;
            end
            pending = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=expired expected=done");
    finishRun();
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitFlag(input int bitPos, input string req);
    logic [31:0] v = '0;
    for (int i = 0; i < 400; i++) begin
      regRead(3'd5, v);
      if (v[bitPos]) break;
    end
    checkEq(req, 32'(v[bitPos]), 32'd1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      regRead(3'(a), v);
      checkEq("R3 reset register", v, 32'h0);
    end
    checkEq("R9 reset irq", 32'(irq), 32'h0);
    checkEq("R11 reset memReq", 32'(memReq), 32'h0);
  endtask

  task automatic testAlign();
    logic [31:0] v;
    regWrite(3'd0, 32'h0000_2003);
    regRead(3'd0, v);
    checkEq("R1 outbound address", v, 32'h0000_2000);
    regWrite(3'd2, 32'hFFFF_FFFF);
    regRead(3'd2, v);
    checkEq("R1 inbound address", v, 32'hFFFF_FFFC);
  endtask

  task automatic testOutbound();
    logic [31:0] v;
    int base = logCount;
    logic [31:0] words [3] = '{32'hA1A2A3A4, 32'hB1B2B3B4, 32'hC1C2C3C4};
    for (int i = 0; i < 3; i++) regWrite(3'd6, words[i]);
    regWrite(3'd0, 32'h100);
    regWrite(3'd1, 32'd10);
    regWrite(3'd5, 32'h1);
    regWrite(3'd4, 32'h1 << 10);
    waitFlag(18, "R7 outbound done flag");
    checkEq("R5 outbound word count", 32'(logCount - base), 32'd3);
    for (int i = 0; i < 3; i++) begin
      checkEq("R5 outbound address", logAddr[base+i], 32'h100 + 32'(4*i));
      checkEq("R10 outbound data", logData[base+i], words[i]);
      checkEq("R3 outbound direction", 32'(logWr[base+i]), 32'd1);
      checkEq("R6 outbound byte enables", 32'(logBe[base+i]), (i == 2) ? 32'h3 : 32'hF);
    end
    checkEq("R9 irq raised", 32'(irq), 32'd1);
    regRead(3'd0, v); checkEq("R5 final address", v, 32'h10C);
    regRead(3'd1, v); checkEq("R5 final count", v, 32'd0);
    regRead(3'd4, v); checkEq("R7 enable cleared", v, 32'h0);
    regWrite(3'd5, 32'h1);
    regRead(3'd5, v);
    checkEq("R8 write zero keeps flag", 32'(v[18]), 32'd1);
    checkEq("R9 irq still high", 32'(irq), 32'd1);
    regWrite(3'd5, (32'h1 << 18) | 32'h1);
    regRead(3'd5, v);
    checkEq("R8 write one clears flag", 32'(v[18]), 32'd0);
    checkEq("R9 irq cleared", 32'(irq), 32'd0);
  endtask

  task automatic testZeroCount();
    logic [31:0] v;
    int base = logCount;
    regWrite(3'd1, 32'd0);
    regWrite(3'd4, 32'h1 << 10);
    repeat (2) @(negedge clk);
    regRead(3'd5, v);
    checkEq("R2 zero count completes", 32'(v[18]), 32'd1);
    checkEq("R2 zero count no request", 32'(logCount - base), 32'd0);
    regRead(3'd4, v);
    checkEq("R2 zero count enable cleared", v, 32'h0);
    regWrite(3'd5, 32'h1 << 18);
  endtask

  task automatic testInbound();
    logic [31:0] v;
    int base = logCount;
    regWrite(3'd2, 32'h200);
    regWrite(3'd3, 32'd7);
    regWrite(3'd5, 32'h0);
    regWrite(3'd4, 32'h1 << 14);
    waitFlag(19, "R7 inbound done flag");
    checkEq("R9 polled without irq", 32'(irq), 32'd0);
    checkEq("R5 inbound word count", 32'(logCount - base), 32'd2);
    checkEq("R5 inbound address 0", logAddr[base], 32'h200);
    checkEq("R5 inbound address 1", logAddr[base+1], 32'h204);
    checkEq("R6 inbound full enables", 32'(logBe[base]), 32'hF);
    checkEq("R6 inbound tail enables", 32'(logBe[base+1]), 32'h7);
    regRead(3'd6, v); checkEq("R10 inbound pop 0", v, memWord(32'h200));
    regRead(3'd6, v); checkEq("R6 inbound tail zeroed", v, memWord(32'h204) & 32'h00FF_FFFF);
    regRead(3'd6, v); checkEq("R10 empty window reads zero", v, 32'h0);
    regWrite(3'd5, 32'h1 << 19);
  endtask

  task automatic testConflictStop();
    logic [31:0] v;
    int base = logCount;
    regWrite(3'd1, 32'd8);
    regWrite(3'd4, 32'h1 << 10);
    regWrite(3'd6, 32'hDEAD_BEEF);
    regRead(3'd5, v);
    checkEq("R10 outbound conflict flag", 32'(v[20]), 32'd1);
    regWrite(3'd2, 32'h300);
    regWrite(3'd3, 32'd40);
    regWrite(3'd4, 32'h1 << 14);
    regRead(3'd4, v);
    checkEq("R4 plain write stops outbound", v, 32'h1 << 14);
    repeat (60) @(negedge clk);
    regRead(3'd6, v);
    checkEq("R10 refused read returns zero", v, 32'h0);
    regRead(3'd5, v);
    checkEq("R10 inbound conflict flag", 32'(v[21]), 32'd1);
    regRead(3'd3, v);
    checkEq("R5 stalled inbound count", v, 32'd8);
    regWrite(3'd4, 32'h0);
    repeat (8) @(negedge clk);
    regRead(3'd5, v);
    checkEq("R4 stop sets no done flag", 32'(v[19]), 32'd0);
    checkEq("R4 only inbound words issued", 32'(logCount - base), 32'd8);
    regRead(3'd6, v);
    checkEq("R10 first stalled word", v, memWord(32'h300));
    for (int i = 1; i < 8; i++) regRead(3'd6, v);
    regWrite(3'd5, (32'h1 << 20) | (32'h1 << 21));
    regRead(3'd5, v);
    checkEq("R8 conflict flags cleared", v & 32'h0030_0000, 32'h0);
  endtask

  task automatic testAlternate();
    logic [31:0] v;
    int base = logCount;
    int wrIdx = 0;
    logic [31:0] words [3] = '{32'h0101_0101, 32'h0202_0202, 32'h0303_0303};
    for (int i = 0; i < 3; i++) regWrite(3'd6, words[i]);
    regWrite(3'd0, 32'h400);
    regWrite(3'd1, 32'd12);
    regWrite(3'd2, 32'h500);
    regWrite(3'd3, 32'd12);
    regWrite(3'd4, (32'h1 << 10) | (32'h1 << 14));
    waitFlag(18, "R7 outbound done in shared run");
    waitFlag(19, "R7 inbound done in shared run");
    checkEq("R12 word total", 32'(logCount - base), 32'd6);
    for (int i = 0; i < 5; i++)
      checkEq("R12 alternation", 32'(logWr[base+i] ^ logWr[base+i+1]), 32'd1);
    for (int i = 0; i < 6; i++) begin
      if (logWr[base+i]) begin
        checkEq("R10 rejected word absent", logData[base+i], words[wrIdx]);
        wrIdx++;
      end
    end
    for (int i = 0; i < 3; i++) regRead(3'd6, v);
    regWrite(3'd5, (32'h1 << 18) | (32'h1 << 19));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAlign();
    testOutbound();
    testZeroCount();
    testInbound();
    testConflictStop();
    testAlternate();
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule